// File: doc/BRIEF.md
# Slave-Serial Configuration Sequencer

This block reconfigures an FPGA that is loaded through a slave serial interface, by driving an 8-bit parallel pin bus at a fixed sample rate. A pulse on `go` starts the sequence. First, a repeated termination pattern on the spare pins stops the design that is currently running in the target. Next, PROG is pulsed with the serial clock held at its idle level. The block then polls the target's INIT line once per sample until INIT reads high. If INIT stays low for the whole timeout window, the termination and PROG steps run again, up to a bounded number of attempts.

Once INIT is high, configuration bytes arrive on a valid/ready stream. Each bit, most significant bit first, becomes two pin samples. The first sample carries the data bit with the clock bit set, and the second carries the same data bit with the clock bit cleared. Level shifters on the board invert the clock, so the target sees a rising clock edge while the data line is stable. When the byte flagged as last has been sent, `done` is raised. When every attempt times out, `err` is raised. Both flags hold until the next `go`.

One pin sample lasts `SAMPLE_DIV` clock cycles. The default of 133 cycles gives roughly 750 k samples per second from a 100 MHz clock.

Top module: `sscfg_seq`

## Requirements
- R1: During and right after reset, `pins` is 0x01 (bit 0, the serial clock pin, high and every other bit low), and `done`, `err` and `cfg_ready` are 0.
- R2: After `go` is accepted, the first 4×8 samples form the termination pattern: bit 7 is high in every sample, bit 3 is high at positions 2, 4 and 6 of each group of eight, bit 2 is high at positions 0, 1, 3, 5 and 7, and all other bits are low (values 0x84 and 0x88).
- R3: The termination pattern is followed by one sample of 0x01 and then `PROG_LEN` samples of 0x03 (bit 1, the PROG pin, high while the clock pin stays high).
- R4: The block then outputs 0x01 and samples `init_in` once per sample boundary. A high level seen at a boundary makes the next sample the first data sample. `init_in` has no effect outside this wait window.
- R5: If `init_in` is low at `INIT_TIMEOUT` consecutive boundaries, the sequence restarts from the termination pattern. When attempt `MAX_TRIES` times out, `err` rises together with its last wait sample, and `pins` stays 0x01.
- R6: Each data bit b, most significant bit first, gives the sample (b<<6)|0x01 followed by the sample b<<6.
- R7: `cfg_ready` is high only in the data phase and only while no byte is held. If no byte is available at a sample boundary, `pins` keeps its previous value.
- R8: After the second sample of the last bit of the byte flagged with `cfg_last` has lasted one full period, `done` rises, `pins` returns to 0x01 and `cfg_ready` stays low. `done` and `err` hold until the next `go` and are never high together.
- R9: Every sample lasts exactly `SAMPLE_DIV` clock cycles. The first sample starts `SAMPLE_DIV` cycles after the clock edge that accepts `go`.
- R10: `go` is ignored while a sequence is running, that is, in any state other than idle, done or failed.
- R11: Pin bits 4 and 5 are always driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe, accepted when idle, done or failed |
| cfg_data | input | DATA_W | Configuration byte |
| cfg_last | input | 1 | Marks the final configuration byte |
| cfg_valid | input | 1 | Configuration byte is valid |
| cfg_ready | output | 1 | Sequencer can take a byte |
| init_in | input | 1 | Sampled level of the target's INIT line |
| pins | output | 8 | Pin sample bus |
| done | output | 1 | Configuration stream finished |
| err | output | 1 | All attempts timed out waiting for INIT |

## Verification
The assertions check the per-cycle shape of the pin bus on every cycle. Termination samples toggle exactly one of bits 2 and 3, PROG only appears with the clock pin high, and the spare pins stay low. They also check that `done` and `err` are exclusive, hold until `go`, and come with an idle bus, and that the bus stays frozen while the sequencer is starved of bytes. The exact order and duration of every sample are shown only by the bench scenarios, which compare the bus twice per sample period against a computed sequence. The same applies to the boundary at which INIT is seen, the attempt count before failure, and MSB-first encoding across all 256 byte values.

// File: rtl/sscfg_pkg.sv
package sscfg_pkg;

    localparam int PIN_W     = 8;
    localparam int B_CLK     = 0;   // serial clock, inverted by the board
    localparam int B_PROG    = 1;   // PROG request
    localparam int B_TERM_A  = 2;   // termination toggle A
    localparam int B_TERM_B  = 3;   // termination toggle B
    localparam int B_DIN     = 6;   // serial data
    localparam int B_TERM_EN = 7;   // termination enable level
    localparam int TERM_GRP  = 8;   // samples per termination group

    typedef logic [PIN_W-1:0] pins_t;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_TERM   = 3'd1,
        S_PRE    = 3'd2,
        S_PULSE  = 3'd3,
        S_WAIT   = 3'd4,
        S_STREAM = 3'd5,
        S_DONE   = 3'd6,
        S_FAIL   = 3'd7
    } seq_state_e;

    // Output of the bit encoder toward the sequencer
    typedef struct packed {
        logic  have;       // a byte is being encoded
        logic  final_smp;  // current sample is the byte's last one
        logic  last_byte;  // the held byte closes the stream
        pins_t sample;     // pin value of the current sample
    } enc_t;

    function automatic pins_t idle_pins();
        pins_t p = '0;
        p[B_CLK] = 1'b1;
        return p;
    endfunction

    function automatic pins_t prog_pins();
        pins_t p = idle_pins();
        p[B_PROG] = 1'b1;
        return p;
    endfunction

    // Position 0 and odd positions use toggle A, other even positions toggle B
    function automatic pins_t term_pins(input logic [2:0] pos);
        pins_t p = '0;
        p[B_TERM_EN] = 1'b1;
        if (pos != 3'd0 && !pos[0]) p[B_TERM_B] = 1'b1;
        else                         p[B_TERM_A] = 1'b1;
        return p;
    endfunction

    function automatic pins_t data_pins(input logic din, input logic clk_hi);
        pins_t p = '0;
        p[B_DIN] = din;
        p[B_CLK] = clk_hi;
        return p;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/sscfg_tick.sv
module sscfg_tick #(
    parameter int DIV = 133
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst || restart)   div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                  div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/sscfg_bitenc.sv
module sscfg_bitenc
    import sscfg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic              tick,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              last_i,
    input  logic              valid_i,
    output logic              ready_o,
    output enc_t              enc_o
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic              lst_q;
    logic              loaded_q;
    logic [IW-1:0]     idx_q;
    logic              ph_q;     // 0: clock-high sample, 1: clock-low sample

    assign ready_o = en && !loaded_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q     <= '0;
            lst_q    <= 1'b0;
            loaded_q <= 1'b0;
            idx_q    <= '0;
            ph_q     <= 1'b0;
        end else if (ready_o && valid_i) begin
            sh_q     <= byte_i;
            lst_q    <= last_i;
            loaded_q <= 1'b1;
            idx_q    <= '0;
            ph_q     <= 1'b0;
        end else if (en && tick && loaded_q) begin
            if (!ph_q) begin
                ph_q <= 1'b1;
            end else begin
                ph_q <= 1'b0;
                sh_q <= sh_q << 1;
                if (idx_q == LAST_IDX) begin
                    loaded_q <= 1'b0;
                    idx_q    <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        enc_o.have      = loaded_q;
        enc_o.final_smp = ph_q && (idx_q == LAST_IDX);
        enc_o.last_byte = lst_q;
        enc_o.sample    = data_pins(sh_q[DATA_W-1], !ph_q);
    end
endmodule

// File: rtl/sscfg_fsm.sv
module sscfg_fsm
    import sscfg_pkg::*;
#(
    parameter int TERM_REPS    = 4,
    parameter int PROG_LEN     = 2,
    parameter int INIT_TIMEOUT = 7500,
    parameter int MAX_TRIES    = 10
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  go,
    input  logic  init_i,
    input  enc_t  enc_i,
    output pins_t pins_o,
    output logic  stream_o,
    output logic  restart_o,
    output logic  done_o,
    output logic  err_o
);
    localparam int TERM_LEN = TERM_REPS * TERM_GRP;
    localparam int CNT_MAX  = max3(TERM_LEN, PROG_LEN, INIT_TIMEOUT);
    localparam int CW       = $clog2(CNT_MAX + 1) < 3 ? 3 : $clog2(CNT_MAX + 1);
    localparam int TW       = $clog2(MAX_TRIES + 1) < 1 ? 1 : $clog2(MAX_TRIES + 1);
    localparam logic [CW-1:0] TERM_END = CW'(TERM_LEN - 1);
    localparam logic [CW-1:0] PROG_END = CW'(PROG_LEN - 1);
    localparam logic [CW-1:0] WAIT_END = CW'(INIT_TIMEOUT - 1);
    localparam logic [TW-1:0] TRY_END  = TW'(MAX_TRIES - 1);

    seq_state_e     st_q;
    logic [CW-1:0]  cnt_q;
    logic [TW-1:0]  tries_q;
    logic           fin_q;
    pins_t          pins_q;
    logic           accept;

    assign accept    = go && (st_q == S_IDLE || st_q == S_DONE || st_q == S_FAIL);
    assign restart_o = accept;
    assign stream_o  = (st_q == S_STREAM) && !fin_q;
    assign pins_o    = pins_q;
    assign done_o    = (st_q == S_DONE);
    assign err_o     = (st_q == S_FAIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            cnt_q   <= '0;
            tries_q <= '0;
            fin_q   <= 1'b0;
            pins_q  <= idle_pins();
        end else if (accept) begin
            st_q    <= S_TERM;
            cnt_q   <= '0;
            tries_q <= '0;
            fin_q   <= 1'b0;
        end else if (tick) begin
            unique case (st_q)
                S_TERM: begin
                    pins_q <= term_pins(cnt_q[2:0]);
                    if (cnt_q == TERM_END) begin
                        st_q  <= S_PRE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_PRE: begin
                    pins_q <= idle_pins();
                    st_q   <= S_PULSE;
                    cnt_q  <= '0;
                end
                S_PULSE: begin
                    pins_q <= prog_pins();
                    if (cnt_q == PROG_END) begin
                        st_q  <= S_WAIT;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_WAIT: begin
                    pins_q <= idle_pins();
                    if (init_i) begin
                        st_q  <= S_STREAM;
                        fin_q <= 1'b0;
                        cnt_q <= '0;
                    end else if (cnt_q == WAIT_END) begin
                        cnt_q <= '0;
                        if (tries_q == TRY_END) begin
                            st_q <= S_FAIL;
                        end else begin
                            tries_q <= tries_q + 1'b1;
                            st_q    <= S_TERM;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_STREAM: begin
                    if (fin_q) begin
                        st_q   <= S_DONE;
                        pins_q <= idle_pins();
                    end else if (enc_i.have) begin
                        pins_q <= enc_i.sample;
                        if (enc_i.final_smp && enc_i.last_byte) fin_q <= 1'b1;
                    end
                end
                default: begin
                    pins_q <= idle_pins();
                end
            endcase
        end
    end
endmodule

// File: rtl/sscfg_seq.sv
module sscfg_seq
    import sscfg_pkg::*;
#(
    parameter int SAMPLE_DIV   = 133,
    parameter int DATA_W       = 8,
    parameter int TERM_REPS    = 4,
    parameter int PROG_LEN     = 2,
    parameter int INIT_TIMEOUT = 7500,
    parameter int MAX_TRIES    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              cfg_last,
    input  logic              cfg_valid,
    output logic              cfg_ready,
    input  logic              init_in,
    output logic [PIN_W-1:0]  pins,
    output logic              done,
    output logic              err
);
    logic  tick;
    logic  restart;
    logic  stream_en;
    enc_t  enc;
    pins_t pins_w;

    sscfg_tick #(.DIV(SAMPLE_DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick)
    );

    sscfg_bitenc #(.DATA_W(DATA_W)) u_enc (
        .clk     (clk),
        .rst     (rst),
        .clr     (restart),
        .en      (stream_en),
        .tick    (tick),
        .byte_i  (cfg_data),
        .last_i  (cfg_last),
        .valid_i (cfg_valid),
        .ready_o (cfg_ready),
        .enc_o   (enc)
    );

    sscfg_fsm #(
        .TERM_REPS    (TERM_REPS),
        .PROG_LEN     (PROG_LEN),
        .INIT_TIMEOUT (INIT_TIMEOUT),
        .MAX_TRIES    (MAX_TRIES)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .go        (go),
        .init_i    (init_in),
        .enc_i     (enc),
        .pins_o    (pins_w),
        .stream_o  (stream_en),
        .restart_o (restart),
        .done_o    (done),
        .err_o     (err)
    );

    assign pins = pins_w;
endmodule

// File: rtl/sscfg_seq_chk.sv
module sscfg_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       go,
    input logic       cfg_ready,
    input logic [7:0] pins,
    input logic       done,
    input logic       err
);
    a_r11_spare_low: assert property (@(posedge clk) disable iff (rst)
        pins[5:4] == 2'b00);

    a_r2_term_shape: assert property (@(posedge clk) disable iff (rst)
        pins[7] |-> ((pins[2] ^ pins[3]) && pins[1:0] == 2'b00 && !pins[6]));

    a_r3_prog_with_clk_idle: assert property (@(posedge clk) disable iff (rst)
        pins[1] |-> (pins[0] && pins[7:2] == 6'd0));

    a_r8_done_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    a_r8_done_idle_bus: assert property (@(posedge clk) disable iff (rst)
        done |-> (pins == 8'h01 && !cfg_ready));

    a_r5_err_idle_bus: assert property (@(posedge clk) disable iff (rst)
        err |-> (pins == 8'h01 && !cfg_ready));

    a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !go) |=> done);

    a_r5_err_holds: assert property (@(posedge clk) disable iff (rst)
        (err && !go) |=> err);

    a_r7_starved_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_ready && $past(cfg_ready)) |-> $stable(pins));
endmodule

bind sscfg_seq sscfg_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .cfg_ready (cfg_ready),
    .pins      (pins),
    .done      (done),
    .err       (err)
);

// File: tb/sscfg_seq_tb.sv
module sscfg_seq_tb;
    localparam int DIV = 4;
    localparam int TO  = 6;
    localparam int PL  = 2;
    localparam int MT  = 10;
    localparam int KR  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       go = 1'b0;
    logic [7:0] cfg_data;
    logic       cfg_last;
    logic       cfg_valid;
    logic       cfg_ready;
    logic       init_in = 1'b0;
    logic [7:0] pins;
    logic       done;
    logic       err;

    sscfg_seq #(
        .SAMPLE_DIV(DIV), .DATA_W(8), .TERM_REPS(KR),
        .PROG_LEN(PL), .INIT_TIMEOUT(TO), .MAX_TRIES(MT)
    ) u_dut (
        .clk(clk), .rst(rst), .go(go), .cfg_data(cfg_data), .cfg_last(cfg_last),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .init_in(init_in),
        .pins(pins), .done(done), .err(err)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] bval [0:255];
    int nbytes = 0;
    int bidx = 0;
    int stall_idx = -1;
    int stall_rel = 0;
    int slot_now = -1;

    logic [7:0] e_pin[$];
    bit         e_done[$];
    bit         e_err[$];
    string      e_tag[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] p, input bit d, input bit e, input string t);
        e_pin.push_back(p);
        e_done.push_back(d);
        e_err.push_back(e);
        e_tag.push_back(t);
    endtask

    // Byte source: one byte offered per handshake, optionally held back
    initial begin
        bit fire;
        cfg_valid = 1'b0;
        cfg_data  = 8'h00;
        cfg_last  = 1'b0;
        forever begin
            @(negedge clk);
            fire = cfg_valid && cfg_ready;
            @(posedge clk);
            #1;
            if (fire) bidx++;
            cfg_valid = (bidx < nbytes) && (bidx != stall_idx || slot_now >= stall_rel);
            cfg_data  = (bidx < nbytes) ? bval[bidx] : 8'h00;
            cfg_last  = (bidx == nbytes - 1);
        end
    end

    // Expected sample sequence from the requirements
    task automatic build(input int nb, input int init_from, input int st_idx,
                         input int st_n);
        bit ok = 1'b0;
        logic [7:0] prev;
        e_pin.delete(); e_done.delete(); e_err.delete(); e_tag.delete();
        stall_rel = 0;
        for (int a = 0; a < MT && !ok; a++) begin
            for (int k = 0; k < KR * 8; k++) begin
                int pos = k % 8;
                logic [7:0] p = 8'h80 | ((pos != 0 && pos % 2 == 0) ? 8'h08 : 8'h04);
                push(p, 0, 0, (a == 0) ? "R2" : "R5");
            end
            push(8'h01, 0, 0, "R3");
            for (int k = 0; k < PL; k++) push(8'h03, 0, 0, "R3");
            for (int w = 0; w < TO; w++) begin
                int j = e_pin.size();
                bit det = (j - 1 >= init_from);
                bit fl  = !det && a == MT - 1 && w == TO - 1;
                push(8'h01, 0, fl, fl ? "R5" : "R4");
                if (det) begin
                    ok = 1'b1;
                    break;
                end
            end
        end
        if (ok) begin
            prev = 8'h01;
            for (int b = 0; b < nb; b++) begin
                if (b == st_idx) begin
                    stall_rel = e_pin.size() - 1 + st_n;
                    for (int k = 0; k < st_n; k++) push(prev, 0, 0, "R7");
                end
                for (int i = 7; i >= 0; i--) begin
                    logic v = bval[b][i];
                    push({1'b0, v, 5'b0, 1'b1}, 0, 0, "R6");
                    push({1'b0, v, 6'b0}, 0, 0, "R6");
                    prev = {1'b0, v, 6'b0};
                end
            end
            for (int k = 0; k < 3; k++) push(8'h01, 1, 0, "R8");
        end else begin
            for (int k = 0; k < 2; k++) push(8'h01, 0, 1, "R5");
        end
    endtask

    task automatic run(input int nb, input int init_from, input int st_idx,
                       input int st_n, input int go_extra);
        build(nb, init_from, st_idx, st_n);
        stall_idx = st_idx;
        nbytes    = nb;
        bidx      = 0;
        slot_now  = -1;
        init_in   = 1'b0;
        @(negedge clk);
        go = 1'b1;
        @(posedge clk);
        #1 go = 1'b0;
        repeat (DIV) @(posedge clk);
        for (int s = 0; s < e_pin.size(); s++) begin
            @(negedge clk);
            slot_now = s;
            chk(pins == e_pin[s], e_tag[s], $sformatf("pins slot %0d", s), {24'b0, pins}, {24'b0, e_pin[s]});
            chk(done == e_done[s], "R8", $sformatf("done slot %0d", s), {31'b0, done}, {31'b0, e_done[s]});
            chk(err == e_err[s], "R5", $sformatf("err slot %0d", s), {31'b0, err}, {31'b0, e_err[s]});
            chk(pins[5:4] == 2'b00, "R11", "spare pins", {30'b0, pins[5:4]}, 32'd0);
            if (e_done[s]) chk(!cfg_ready, "R8", "ready after done", {31'b0, cfg_ready}, 32'd0);
            if (s == go_extra + 1)
                chk(pins == e_pin[s], "R10", "go while busy", {24'b0, pins}, {24'b0, e_pin[s]});
            init_in = (s >= init_from);
            if (s == go_extra) go = 1'b1;
            for (int c = 0; c < DIV - 1; c++) begin
                @(posedge clk);
                #1 go = 1'b0;
            end
            @(negedge clk);
            chk(pins == e_pin[s], "R9", $sformatf("pins end of slot %0d", s), {24'b0, pins}, {24'b0, e_pin[s]});
            @(posedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(pins == 8'h01, "R1", "pins after reset", {24'b0, pins}, 32'h01);
        chk(!done, "R1", "done after reset", {31'b0, done}, 32'd0);
        chk(!err, "R1", "err after reset", {31'b0, err}, 32'd0);
        chk(!cfg_ready, "R1", "ready after reset", {31'b0, cfg_ready}, 32'd0);

        // S1: INIT already high, three bytes
        bval[0] = 8'hA5; bval[1] = 8'h3C; bval[2] = 8'h81;
        run(3, 0, -1, 0, -100);

        // S2: INIT late inside the window, stall before byte 2, go during data
        bval[0] = 8'h00; bval[1] = 8'hFF; bval[2] = 8'h5A; bval[3] = 8'hC3;
        run(4, 38, 2, 5, 50);

        // S3: INIT never rises, go during termination pattern
        bval[0] = 8'h77;
        run(1, 1 << 30, -1, 0, 10);

        // S4: first attempt times out, INIT high during second termination
        bval[0] = 8'h12; bval[1] = 8'hED;
        run(2, 45, -1, 0, -100);

        // S5: every byte value once, MSB first
        for (int i = 0; i < 256; i++) bval[i] = 8'(i);
        run(256, 0, -1, 0, -100);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule